// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU

This execution unit works on 64-bit operand words that are split into independent lanes. Each operation picks the lane width: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every operation also chooses whether lanes hold signed or unsigned values, and whether addition and subtraction wrap modulo the lane size or clip at the lane's limits.

The unit supports lane-wise add, subtract, equality compare, greater-than compare, minimum and maximum. Carries never cross a lane boundary, and lane 0 sits in the least significant bits. A caller presents two source words with the control fields and a valid strobe. The result appears in an output register one clock later.

Top module: `simd_lane_alu`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` to 0 and `result` to all zeros at the next clock edge.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge. `result` loads only on an edge where `in_valid` is 1 and holds its value otherwise.
- R3: `lane_sz` encodes 0 as 8-bit lanes, 1 as 16-bit lanes, and 2 or 3 as 32-bit lanes. Lane i occupies bits i*n to i*n+n-1. No carry or borrow passes from one lane into the next.
- R4: `op` 0 adds and `op` 1 subtracts (a minus b) lane by lane. With `sat_mode` 0 each lane result is taken modulo 2^n, whatever the signedness.
- R5: With `sat_mode` 1 and `is_signed` 1, a lane add or subtract result is clamped to the range -2^(n-1) to 2^(n-1)-1.
- R6: With `sat_mode` 1 and `is_signed` 0, a lane add or subtract result is clamped to the range 0 to 2^n-1.
- R7: `op` 2 (equal) and `op` 3 (a greater than b, using the signedness chosen by `is_signed`) write all ones into each true lane and all zeros into each false lane. `sat_mode` has no effect on them.
- R8: `op` 4 returns the lane-wise minimum and `op` 5 the lane-wise maximum of a and b, compared as signed or unsigned according to `is_signed`.
- R9: The unused `op` codes 6 and 7 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| op | input | 3 | Operation code (0 add, 1 sub, 2 eq, 3 gt, 4 min, 5 max) |
| lane_sz | input | 2 | Lane width select (0: 8, 1: 16, 2/3: 32 bits) |
| is_signed | input | 1 | Treat lanes as two's-complement signed |
| sat_mode | input | 1 | Clip add/sub results instead of wrapping |
| src_a | input | 64 | First source word |
| src_b | input | 64 | Second source word |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered lane-wise result |

## Verification
The only state is the result register and its valid flag. A wrong lane computation or a wrongly latched control field therefore shows at `result` on the very next edge after the request. It shows as one or more lanes that differ from the lane-by-lane reference. A carry leaking across a boundary corrupts the lane above the one at fault. A wrong clamp shows as a lane stuck at the wrong limit. A fault in the load enable shows up the first idle cycle after a request, as a `result` that changes while `in_valid` is low.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int WORD_W  = 64;
    localparam int NUM_SZ  = 3;
    localparam int MIN_LW  = 8;
    localparam int OP_W    = 3;
    localparam int SZ_W    = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_EQ   = 3'd2,
        OP_GT   = 3'd3,
        OP_MIN  = 3'd4,
        OP_MAX  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } opcode_e;

    typedef enum logic [SZ_W-1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_32B = 2'd3
    } lane_sz_e;

    typedef struct packed {
        opcode_e op;
        logic    sgn;
        logic    sat;
    } lane_ctrl_t;

    // Index of the slice (0: 8-bit, 1: 16-bit, 2: 32-bit) that serves a width code.
    function automatic int unsigned slice_index(lane_sz_e sz);
        case (sz)
            SZ_8:    return 0;
            SZ_16:   return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_alu_pkg::*;
#(
    parameter int LW = 8
) (
    input  lane_ctrl_t      ctrl,
    input  logic [LW-1:0]   a,
    input  logic [LW-1:0]   b,
    output logic [LW-1:0]   y
);
    localparam int XW = LW + 2;

    logic signed [XW-1:0] ax, bx, arith, hi_lim, lo_lim;
    logic                 a_gt_b;

    always_comb begin
        ax     = $signed({{2{ctrl.sgn & a[LW-1]}}, a});
        bx     = $signed({{2{ctrl.sgn & b[LW-1]}}, b});
        arith  = (ctrl.op == OP_SUB) ? (ax - bx) : (ax + bx);
        hi_lim = ctrl.sgn ? $signed({3'b000, {(LW-1){1'b1}}})
                          : $signed({2'b00, {LW{1'b1}}});
        lo_lim = ctrl.sgn ? $signed({3'b111, {(LW-1){1'b0}}})
                          : $signed({XW{1'b0}});
        a_gt_b = ax > bx;

        case (ctrl.op)
            OP_ADD, OP_SUB: begin
                if (ctrl.sat && (arith > hi_lim))
                    y = hi_lim[LW-1:0];
                else if (ctrl.sat && (arith < lo_lim))
                    y = lo_lim[LW-1:0];
                else
                    y = arith[LW-1:0];
            end
            OP_EQ:   y = {LW{a == b}};
            OP_GT:   y = {LW{a_gt_b}};
            OP_MIN:  y = a_gt_b ? b : a;
            OP_MAX:  y = a_gt_b ? a : b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_slice.sv
module simd_slice
    import simd_alu_pkg::*;
#(
    parameter int LW = 8
) (
    input  lane_ctrl_t        ctrl,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);
    localparam int NLANES = WORD_W / LW;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        simd_lane #(.LW(LW)) u_lane (
            .ctrl (ctrl),
            .a    (a[i*LW +: LW]),
            .b    (b[i*LW +: LW]),
            .y    (y[i*LW +: LW])
        );
    end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [SZ_W-1:0]   lane_sz,
    input  logic              is_signed,
    input  logic              sat_mode,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    lane_ctrl_t        ctrl;
    logic [WORD_W-1:0] slice_y [NUM_SZ];
    logic [WORD_W-1:0] next_y;

    assign ctrl.op  = opcode_e'(op);
    assign ctrl.sgn = is_signed;
    assign ctrl.sat = sat_mode;

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_width
        simd_slice #(.LW(MIN_LW << g)) u_slice (
            .ctrl (ctrl),
            .a    (src_a),
            .b    (src_b),
            .y    (slice_y[g])
        );
    end

    always_comb begin
        next_y = slice_y[slice_index(lane_sz_e'(lane_sz))];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= next_y;
        end
    end

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk
    import simd_alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [SZ_W-1:0]   lane_sz,
    input logic              is_signed,
    input logic              sat_mode,
    input logic [WORD_W-1:0] src_a,
    input logic [WORD_W-1:0] src_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    // Every bit of a lane must match the top bit of that lane.
    function automatic logic lanes_uniform(logic [WORD_W-1:0] w, logic [SZ_W-1:0] sz);
        int n;
        logic ok;
        n  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        ok = 1'b1;
        for (int k = 0; k < WORD_W; k++)
            if (w[k] != w[(k / n) * n + n - 1]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic bytes_not_below(logic [WORD_W-1:0] r, logic [WORD_W-1:0] a);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < WORD_W / 8; i++)
            if (r[i*8 +: 8] < a[i*8 +: 8]) ok = 1'b0;
        return ok;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && (result == '0))); // R1

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R2

    AST_CMP_MASK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 3'd2 || op == 3'd3)) |=> lanes_uniform(result, $past(lane_sz))); // R7

    AST_USAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0 && !is_signed && sat_mode && lane_sz == 2'd0)
        |=> bytes_not_below(result, $past(src_a))); // R6

endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .lane_sz   (lane_sz),
    .is_signed (is_signed),
    .sat_mode  (sat_mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_simd_lane_alu.sv
module sim_simd_lane_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  lane_sz = '0;
    logic        is_signed = 1'b0;
    logic        sat_mode = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    simd_lane_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
        .is_signed(is_signed), .sat_mode(sat_mode), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic int lane_bits(int sz);
        return (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    endfunction

    // Lane-by-lane arithmetic reference.
    function automatic logic [63:0] ref_word(int opc, int sz, bit sgn, bit sat,
                                             logic [63:0] a, logic [63:0] b);
        int n = lane_bits(sz);
        longint mask = (longint'(1) << n) - 1;
        longint half = longint'(1) << (n - 1);
        logic [63:0] w = '0;
        for (int i = 0; i < 64 / n; i++) begin
            longint x = longint'(a >> (i * n)) & mask;
            longint y = longint'(b >> (i * n)) & mask;
            longint r;
            if (sgn && x >= half) x = x - (longint'(1) << n);
            if (sgn && y >= half) y = y - (longint'(1) << n);
            case (opc)
                0: r = x + y;
                1: r = x - y;
                2: r = (x == y) ? mask : 0;
                3: r = (x > y) ? mask : 0;
                4: r = (x < y) ? x : y;
                5: r = (x > y) ? x : y;
                default: r = 0;
            endcase
            if (sat && opc < 2) begin
                longint hi = sgn ? half - 1 : mask;
                longint lo = sgn ? -half : 0;
                if (r > hi) r = hi;
                if (r < lo) r = lo;
            end
            w = w | (64'(r & mask) << (i * n));
        end
        return w;
    endfunction

    function automatic string tag_of(int opc, bit sgn, bit sat);
        if (opc < 2) return sat ? (sgn ? "R5" : "R6") : "R4";
        if (opc < 4) return "R7";
        if (opc < 6) return "R8";
        return "R9";
    endfunction

    function automatic logic [63:0] mk_word(int sz);
        int n = lane_bits(sz);
        longint mask = (longint'(1) << n) - 1;
        logic [63:0] w = '0;
        for (int i = 0; i < 64 / n; i++) begin
            longint v;
            case ($urandom % 6)
                0: v = 0;
                1: v = 1;
                2: v = mask;
                3: v = longint'(1) << (n - 1);
                4: v = (longint'(1) << (n - 1)) - 1;
                default: v = longint'({$urandom, $urandom}) & mask;
            endcase
            w = w | (64'(v) << (i * n));
        end
        return w;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Issue one operation and compare the result one edge later.
    task automatic run_op(int opc, int sz, bit sgn, bit sat,
                          logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        op = opc[2:0]; lane_sz = sz[1:0]; is_signed = sgn; sat_mode = sat;
        src_a = a; src_b = b; in_valid = 1'b1;
        @(posedge clk);
        #1;
        check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, result, ref_word(opc, sz, sgn, sat, a, b));
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R3: lane boundaries and width codes
        run_op(0, 0, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0101_0101_0101_0101, "R3 byte carry");
        check("R3 byte isolate", result, 64'h0100_0100_0100_0100);
        run_op(0, 1, 0, 0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, "R3 half carry");
        check("R3 half isolate", result, 64'h0000_0000_0000_0000);
        run_op(1, 2, 0, 0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, "R3 word borrow");
        check("R3 word isolate", result, 64'h0000_0001_FFFF_FFFF);
        run_op(0, 3, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R3 code3 is 32");
        check("R3 code3 isolate", result, 64'h0000_0000_0000_0000);
        run_op(1, 0, 1, 1, 64'h7F80_0000_0000_0000, 64'h80_01_00_00_00_00_00_00, "R5 sat sub");
        check("R5 clamp", result, 64'h7F80_0000_0000_0000);

        // Corner-rich sweep over every control combination.
        for (int sz = 0; sz < 4; sz++)
            for (int opc = 0; opc < 8; opc++)
                for (int s = 0; s < 4; s++)
                    for (int k = 0; k < 24; k++)
                        run_op(opc, sz, s[0], s[1], mk_word(sz), mk_word(sz),
                               tag_of(opc, s[0], s[1]));

        // Exhaustive byte sweep for add/sub in all four modes.
        for (int opc = 0; opc < 2; opc++)
            for (int s = 0; s < 4; s++)
                for (int av = 0; av < 256; av++)
                    for (int k = 0; k < 4; k++) begin
                        logic [63:0] a = {8{av[7:0]}};
                        logic [63:0] b = '0;
                        for (int l = 0; l < 8; l++)
                            b[l*8 +: 8] = 8'((k * 64 + l * 8 + av * 3) & 255);
                        run_op(opc, 0, s[0], s[1], a, b, tag_of(opc, s[0], s[1]));
                    end

        // R2: idle cycle holds result and drops valid
        run_op(5, 1, 1, 0, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0001, "R8 max");
        held = result;
        @(negedge clk);
        in_valid = 1'b0; src_a = 64'hDEAD_BEEF_0123_4567; op = 3'd0;
        @(posedge clk);
        #1;
        check("R2 valid low", {63'd0, out_valid}, 64'd0);
        check("R2 hold", result, held);
        @(posedge clk);
        #1;
        check("R2 hold again", result, held);

        // R1: reset in mid-run
        run_op(2, 0, 0, 0, 64'h1, 64'h1, "R7 eq");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid valid", {63'd0, out_valid}, 64'd0);
        check("R1 mid result", result, 64'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule